// File: doc/BRIEF.md
# Minimum-Norm Nulling Row Selector

This block decides which transmit layer an ordered successive-interference-cancellation detector resolves next. Each cycle it is offered the rows of the current pseudoinverse, one row per layer slot, every entry a fixed-point complex number. A mask marks the slots whose layers were resolved in earlier iterations. For every slot the block forms the squared Euclidean norm of its row. It then orders all slots with a Batcher odd-even merge network and reports the slot with the smallest norm. A smaller nulling-vector norm gives a higher post-detection SNR.

The result carries the physical slot, a consecutive label counted only over the slots still live (1 up to the number of live slots), the winning metric and the winning row itself, which the next stage uses as its nulling vector. Inputs are taken with a valid/ready handshake. The registered result stays on the outputs until the consumer takes it.

Top module: `nullrow_select`

## Requirements
- R1: `out_metric` equals the sum, over all columns of the selected row, of re² + im², with no square root. Entry (r, c) occupies `in_rows` bits starting at ((r·COLS + c)·2)·DATA_W: the real part sits in the low DATA_W bits and the imaginary part in the next DATA_W bits, both two's complement.
- R2: The selected slot has the smallest metric among slots whose `in_done` bit is 0.
- R3: When several live slots share the smallest metric, the lowest slot number wins.
- R4: A slot with `in_done` bit 1 is never selected while any slot is live. When every slot is done, the result is slot 0 with label 0 and a metric of all ones.
- R5: `out_label` is 1 plus the number of live slots below the selected slot. Labels therefore run 1 to the live count.
- R6: `out_row` equals the selected slot's input row, bit for bit.
- R7: An input is accepted on a rising edge where `in_valid` and `in_ready` are both 1, and `out_valid` is 1 in the following cycle. `in_ready` is 1 exactly when no result is held or `out_ready` is 1. Inputs offered while `in_ready` is 0 have no effect.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output stays unchanged. Once `out_ready` is 1 with nothing new accepted, `out_valid` falls on the next edge.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.
- R10: Full-scale entries (−32768 in both parts) produce the exact metric with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input set offered |
| in_ready | output | 1 | Input set can be taken |
| in_rows | input | ROWS·COLS·2·DATA_W | All candidate rows, packed as in R1 |
| in_done | input | ROWS | Bit r set: slot r already detected |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_slot | output | $clog2(ROWS) | Physical slot of the winner |
| out_label | output | $clog2(ROWS+1) | Label among live slots, 0 if none live |
| out_metric | output | METRIC_W | Squared norm of the winner |
| out_row | output | COLS·2·DATA_W | Winning row, the nulling vector |

## Verification
Random rows at full range separate the ordering by metric magnitude (R1, R2). Random rows drawn from {−1, 0, 1} produce many equal norms, which exposes the tie rule and the slot tiebreak inside the sort key (R3). Random and directed masks, including a masked slot that holds the true minimum, a single live slot and an all-done set, separate the masking from label counting (R4, R5). A stalled consumer with new data offered at the same time shows that the result is held and that the offer is ignored (R7, R8).

// File: rtl/nrs_pkg.sv
package nrs_pkg;

   // true when v is a power of two
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // true when position a is the lower end of a compare-exchange pair
   // (a, a+k) in the odd-even merge layer with block size p on n lanes
   function automatic bit bat_lo(input int a, input int k, input int p, input int n);
      if (a < 0 || a + k >= n) return 1'b0;
      if (a < (k % p)) return 1'b0;
      if (((a - (k % p)) % (2 * k)) >= k) return 1'b0;
      return (a / (2 * p)) == ((a + k) / (2 * p));
   endfunction

endpackage

// File: rtl/nrs_row_norm.sv
module nrs_row_norm #(
   parameter int COLS     = 4,
   parameter int DATA_W   = 16,
   parameter int METRIC_W = 35
) (
   input  logic [COLS*2*DATA_W-1:0] row,
   output logic [METRIC_W-1:0]      metric
);
   localparam int SQ_W  = 2 * DATA_W;
   localparam int PAD_W = METRIC_W - SQ_W;

   logic [SQ_W-1:0] term [0:COLS-1];

   genvar c;
   generate
      for (c = 0; c < COLS; c++) begin : g_col
         logic signed [DATA_W-1:0] re, im;
         logic signed [SQ_W-1:0]   re_sq, im_sq;
         assign re    = row[(c*2)*DATA_W +: DATA_W];
         assign im    = row[(c*2+1)*DATA_W +: DATA_W];
         assign re_sq = re * re;
         assign im_sq = im * im;
         // each square is at most 2^(SQ_W-2), the sum fits unsigned
         assign term[c] = unsigned'(re_sq) + unsigned'(im_sq);
      end
   endgenerate

   always_comb begin
      metric = '0;
      for (int i = 0; i < COLS; i++)
         metric = metric + {{PAD_W{1'b0}}, term[i]};
      // a live metric never reaches the top bit, so all-ones stays above it
      p_headroom_r10: assert (metric[METRIC_W-1] == 1'b0);
   end
endmodule

// File: rtl/nrs_batcher_sort.sv
module nrs_batcher_sort #(
   parameter int N     = 4,
   parameter int KEY_W = 37
) (
   input  logic [N*KEY_W-1:0] keys_in,
   output logic [KEY_W-1:0]   key_min
);
   import nrs_pkg::*;

   localparam int LG = $clog2(N);
   localparam int NL = LG * (LG + 1) / 2;

   logic [KEY_W-1:0] lay [0:NL][0:N-1];

   genvar a, s, t;
   generate
      for (a = 0; a < N; a++) begin : g_in
         assign lay[0][a] = keys_in[a*KEY_W +: KEY_W];
      end
      for (s = 0; s < LG; s++) begin : g_stage
         for (t = 0; t <= s; t++) begin : g_layer
            localparam int P = 1 << s;
            localparam int K = 1 << (s - t);
            localparam int L = s * (s + 1) / 2 + t;
            for (a = 0; a < N; a++) begin : g_lane
               localparam bit LO = bat_lo(a, K, P, N);
               localparam bit HI = bat_lo(a - K, K, P, N);
               if (LO) begin : g_min
                  assign lay[L+1][a] = (lay[L][a] < lay[L][a+K]) ? lay[L][a] : lay[L][a+K];
               end else if (HI) begin : g_max
                  assign lay[L+1][a] = (lay[L][a-K] < lay[L][a]) ? lay[L][a] : lay[L][a-K];
               end else begin : g_pass
                  assign lay[L+1][a] = lay[L][a];
               end
            end
         end
      end
   endgenerate

   assign key_min = lay[NL][0];

   // keys carry their slot, so they are distinct and the last layer is strictly rising
   always_comb begin
      for (int i = 0; i < N - 1; i++)
         p_ascending_r2: assert (lay[NL][i] < lay[NL][i+1]);
   end
endmodule

// File: rtl/nullrow_select.sv
module nullrow_select #(
   parameter int ROWS     = 4,
   parameter int COLS     = 4,
   parameter int DATA_W   = 16,
   parameter int METRIC_W = 35
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   output logic                            in_ready,
   input  logic [ROWS*COLS*2*DATA_W-1:0]   in_rows,
   input  logic [ROWS-1:0]                 in_done,
   output logic                            out_valid,
   input  logic                            out_ready,
   output logic [$clog2(ROWS)-1:0]         out_slot,
   output logic [$clog2(ROWS+1)-1:0]       out_label,
   output logic [METRIC_W-1:0]             out_metric,
   output logic [COLS*2*DATA_W-1:0]        out_row
);
   import nrs_pkg::*;

   localparam int SLOT_W  = $clog2(ROWS);
   localparam int LABEL_W = $clog2(ROWS + 1);
   localparam int ROW_W   = COLS * 2 * DATA_W;
   localparam int KEY_W   = METRIC_W + SLOT_W;
   localparam int MIN_MW  = 2 * DATA_W + $clog2(COLS) + 1;

   generate
      if (!is_pow2(ROWS) || ROWS < 2) begin : g_bad_rows
         $error("ROWS must be a power of two, at least 2");
      end
      if (METRIC_W < MIN_MW) begin : g_bad_metric
         $error("METRIC_W too narrow for a saturated masked metric");
      end
   endgenerate

   logic [ROWS*KEY_W-1:0] keys;
   logic [KEY_W-1:0]      win_key;
   logic [SLOT_W-1:0]     win_slot;
   logic [METRIC_W-1:0]   win_metric;
   logic [LABEL_W-1:0]    win_label;
   logic [LABEL_W-1:0]    below;
   logic                  accept;

   genvar r;
   generate
      for (r = 0; r < ROWS; r++) begin : g_row
         logic [METRIC_W-1:0] m;
         nrs_row_norm #(.COLS(COLS), .DATA_W(DATA_W), .METRIC_W(METRIC_W)) u_norm (
            .row    (in_rows[r*ROW_W +: ROW_W]),
            .metric (m)
         );
         assign keys[r*KEY_W +: KEY_W] = {(in_done[r] ? {METRIC_W{1'b1}} : m), SLOT_W'(r)};
      end
   endgenerate

   nrs_batcher_sort #(.N(ROWS), .KEY_W(KEY_W)) u_sort (
      .keys_in (keys),
      .key_min (win_key)
   );

   assign win_slot   = win_key[SLOT_W-1:0];
   assign win_metric = win_key[KEY_W-1:SLOT_W];

   always_comb begin
      below = '0;
      for (int i = 0; i < ROWS; i++)
         if (SLOT_W'(i) < win_slot && !in_done[i]) below = below + 1'b1;
      win_label = in_done[win_slot] ? '0 : below + 1'b1;
   end

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_slot   <= '0;
         out_label  <= '0;
         out_metric <= '0;
         out_row    <= '0;
      end else if (accept) begin
         out_valid  <= 1'b1;
         out_slot   <= win_slot;
         out_label  <= win_label;
         out_metric <= win_metric;
         out_row    <= in_rows[win_slot*ROW_W +: ROW_W];
      end else if (out_ready) begin
         out_valid  <= 1'b0;
      end
   end

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_slot) && $stable(out_label)
                                  && $stable(out_metric) && $stable(out_row));

   p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   p_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_label == '0 |-> &out_metric);

   p_live_metric_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_label != '0 |-> !(&out_metric));

   p_label_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_label <= LABEL_W'(ROWS));
endmodule

// File: tb/tb_nullrow_select.sv
module tb_nullrow_select;
   localparam int ROWS = 4, COLS = 4, DW = 16, MW = 35;
   localparam int ROW_W = COLS * 2 * DW;
   localparam int ALL_W = ROWS * ROW_W;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n, in_valid, in_ready, out_valid, out_ready;
   logic [ALL_W-1:0] in_rows;
   logic [ROWS-1:0]  in_done;
   logic [1:0]       out_slot;
   logic [2:0]       out_label;
   logic [MW-1:0]    out_metric;
   logic [ROW_W-1:0] out_row;

   nullrow_select #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DW), .METRIC_W(MW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_rows(in_rows), .in_done(in_done), .out_valid(out_valid), .out_ready(out_ready),
      .out_slot(out_slot), .out_label(out_label), .out_metric(out_metric), .out_row(out_row)
   );

   int checks = 0, failures = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint norm_of(input logic [ALL_W-1:0] v, input int r);
      longint s = 0;
      for (int c = 0; c < COLS; c++) begin
         longint re = longint'($signed(v[(r*COLS+c)*2*DW +: DW]));
         longint im = longint'($signed(v[(r*COLS+c)*2*DW+DW +: DW]));
         s += re * re + im * im;
      end
      return s;
   endfunction

   function automatic void put(inout logic [ALL_W-1:0] v, input int r, input int c,
                               input int re, input int im);
      v[(r*COLS+c)*2*DW +: DW]    = DW'(re);
      v[(r*COLS+c)*2*DW+DW +: DW] = DW'(im);
   endfunction

   task automatic expect_out(input logic [ALL_W-1:0] v, input logic [ROWS-1:0] m, input string tag);
      int best = -1; longint bm = 0; int lab = 0; longint em;
      for (int r = 0; r < ROWS; r++)
         if (!m[r] && (best < 0 || norm_of(v, r) < bm)) begin best = r; bm = norm_of(v, r); end
      if (best < 0) begin best = 0; em = (64'd1 << MW) - 1; lab = 0; end
      else begin
         em = bm; lab = 1;
         for (int r = 0; r < best; r++) if (!m[r]) lab++;
      end
      check(out_valid === 1'b1, {tag, " R7 valid"}, longint'(out_valid), 1);
      check(out_slot == 2'(best), {tag, " R2 R3 R4 slot"}, longint'(out_slot), best);
      check(out_label == 3'(lab), {tag, " R5 label"}, longint'(out_label), lab);
      check(longint'(out_metric) == em, {tag, " R1 metric"}, longint'(out_metric), em);
      check(out_row == v[best*ROW_W +: ROW_W], {tag, " R6 row"},
            longint'(out_row[63:0]), longint'(v[best*ROW_W +: 64]));
   endtask

   task automatic apply(input logic [ALL_W-1:0] v, input logic [ROWS-1:0] m, input string tag);
      @(negedge clk);
      in_rows = v; in_done = m; in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      expect_out(v, m, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [ALL_W-1:0] v, a;
      void'($urandom(32'd1234));
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_rows = '0; in_done = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0, "R9 reset valid", longint'(out_valid), 0);
      check(in_ready === 1'b1, "R9 reset ready", longint'(in_ready), 1);

      // R2: distinct norms, minimum in slot 2
      v = '0;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) put(v, r, c, (r == 2) ? 1 : 100 + r, -3 * r);
      apply(v, 4'b0000, "distinct");

      // R4: the smallest row is already detected
      apply(v, 4'b0100, "masked min");

      // R3: all rows equal, then tie between slots 2 and 3 with slot 1 done
      v = '0;
      for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) put(v, r, c, 7, -7);
      apply(v, 4'b0000, "all tie");
      for (int c = 0; c < COLS; c++) begin put(v, 0, c, 9, 9); put(v, 1, c, 1, 0); end
      apply(v, 4'b0010, "tie 2 3");

      // R5: single live slot takes label 1
      apply(v, 4'b0111, "one live");

      // R4: all done
      apply(v, 4'b1111, "all done");

      // R10: full-scale negative entries
      v = '0;
      for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) put(v, r, c, -32768, -32768);
      apply(v, 4'b0001, "full scale");
      check(longint'(out_metric) == 64'd8589934592, "R10 full scale metric",
            longint'(out_metric), 64'd8589934592);

      // R7 R8: stall, with other data offered while not ready
      a = v; put(a, 3, 0, 0, 0);
      @(negedge clk);
      out_ready = 1'b0; in_rows = a; in_done = 4'b0000; in_valid = 1'b1;
      @(negedge clk);
      in_rows = '0; in_done = 4'b0000;
      check(in_ready === 1'b0, "R7 not ready while held", longint'(in_ready), 0);
      repeat (2) @(negedge clk);
      in_valid = 1'b0;
      expect_out(a, 4'b0000, "held R8");
      out_ready = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0, "R8 drained", longint'(out_valid), 0);

      // random sets: full range and small values that force ties
      for (int n = 0; n < 300; n++) begin
         logic [ROWS-1:0] m;
         v = '0;
         for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
               if (n % 2 == 0) put(v, r, c, int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768);
               else put(v, r, c, int'($urandom % 3) - 1, int'($urandom % 3) - 1);
         m = ROWS'($urandom);
         apply(v, m, "random");
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule